// File: doc/BRIEF.md
# Status Event Register with Service Request

This block tracks instrument conditions for a controlling host. Two 16-bit live condition vectors come in: one for operating status and one for faults. Each vector is sampled every clock. Whenever a condition bit rises, the matching bit in that vector's event register is latched. Each event bit then holds until the host collects it. As a result, a condition that appears and vanishes between two host polls is still reported.

The host owns two enable registers, one for each event register. The enabled events are OR-reduced into a single request level. When that level moves from zero to non-zero, the block sends a short notification over a byte-wide valid/ready output. The notification is an exclamation mark followed by the unit address written as two ASCII decimal digits with a leading zero.

A small register port lets the host read both condition registers, read both event registers (a read also clears them), clear chosen event bits by writing ones, and read and write both enable registers.

Top module: `srq_status_events`

## Requirements
- R1: After reset, every event and enable register reads 0 and `msg_valid` is low. A read of a condition register (select 0 for status, 3 for fault) returns the value on the condition input at the sampling edge.
- R2: Status bit 15 is reserved. It reads 0 in the status condition and status event registers, whatever value the input carries on that bit.
- R3: An event bit is set on the clock edge where its condition input is 1 and the previously sampled value was 0. A falling condition sets nothing.
- R4: A set event bit stays at 1 until the host reads its event register (select 1 for status, 4 for fault). The read returns the content from before the edge and clears it. Repeated occurrences leave the bit at 1. A rise that coincides with the clearing read is kept and is not lost.
- R5: A write to an event register clears the bits that are 1 in the write data and leaves all other bits unchanged.
- R6: The enable registers (select 2 for status, 5 for fault) are read/write. An event whose enable bit is 0 never causes a notification.
- R7: A notification is requested only when the OR over both (event AND enable) vectors moves from 0 to non-zero. More enabled events arriving while that OR is already non-zero request nothing.
- R8: A notification is three bytes, in this order: 0x21 ('!'), then the tens digit, then the units digit, each digit being 0x30 plus its value. It covers addresses 0 to 99 and uses a leading zero. The address is captured when the message starts. `msg_valid` first goes high on the second rising edge after the condition edge that sets the event.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid` and `msg_data` hold steady. A byte is consumed on each edge where both are high.
- R10: A request that arises while a message is in flight is held pending. It is sent after the current message, following one idle cycle. At most one request is held pending, however many arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_cond | input | 16 | Live status conditions |
| flt_cond | input | 16 | Live fault conditions |
| unit_addr | input | 7 | Unit address, 0 to 99 |
| reg_sel | input | 3 | Register select: 0 status condition, 1 status event, 2 status enable, 3 fault condition, 4 fault event, 5 fault enable |
| reg_rd | input | 1 | Read strobe; data appears on `reg_rdata` after the edge |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| msg_data | output | 8 | Notification byte |
| msg_valid | output | 1 | Notification byte valid |
| msg_ready | input | 1 | Consumer accepts byte |

## Verification
Read data is checked right after the edge that samples `reg_rd`. An event is due on the same edge that samples the condition, so it is observed through a read issued at the following edge. `msg_valid` is checked twice: low after the edge that sets the event, and high after the next edge. Every sample is taken 1 ns after a rising edge, and inputs are driven at that same point. Message bytes are captured only in cycles where `msg_valid` is high just before a handshake edge. Checks for the absence of a request wait several cycles beyond the two-edge latency.

// File: rtl/srq_status_events.sv
module srq_status_events #(
  parameter int W = 16,
  parameter int ADDR_W = 7,
  parameter logic [W-1:0] STAT_MASK = {1'b0, {(W-1){1'b1}}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      stat_cond,
  input  logic [W-1:0]      flt_cond,
  input  logic [ADDR_W-1:0] unit_addr,
  input  logic [2:0]        reg_sel,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic [7:0]        msg_data,
  output logic              msg_valid,
  input  logic              msg_ready
);
  localparam logic [2:0] SEL_SCOND = 3'd0, SEL_SEVT = 3'd1, SEL_SEN = 3'd2;
  localparam logic [2:0] SEL_FCOND = 3'd3, SEL_FEVT = 3'd4, SEL_FEN = 3'd5;
  localparam logic [ADDR_W-1:0] TEN = ADDR_W'(10);
  localparam logic [7:0] BANG = 8'h21, ZERO_CH = 8'h30;

  logic [W-1:0] scond_q, fcond_q, sevt_q, fevt_q, sen_q, fen_q;
  logic         any_q, busy, pend;
  logic [1:0]   idx;
  logic [ADDR_W-1:0] addr_q;

  wire [W-1:0] scond = stat_cond & STAT_MASK;
  wire [W-1:0] srise = scond & ~scond_q;
  wire [W-1:0] frise = flt_cond & ~fcond_q;

  wire rd_sevt = reg_rd && reg_sel == SEL_SEVT;
  wire rd_fevt = reg_rd && reg_sel == SEL_FEVT;
  wire wr_sevt = reg_wr && reg_sel == SEL_SEVT;
  wire wr_fevt = reg_wr && reg_sel == SEL_FEVT;

  wire [W-1:0] sclr = rd_sevt ? '1 : (wr_sevt ? reg_wdata : '0);
  wire [W-1:0] fclr = rd_fevt ? '1 : (wr_fevt ? reg_wdata : '0);

  wire any_now = (|(sevt_q & sen_q)) | (|(fevt_q & fen_q));
  wire req     = any_now & ~any_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scond_q <= '0;
      fcond_q <= '0;
      sevt_q  <= '0;
      fevt_q  <= '0;
      sen_q   <= '0;
      fen_q   <= '0;
      any_q   <= 1'b0;
    end else begin
      scond_q <= scond;
      fcond_q <= flt_cond;
      sevt_q  <= (sevt_q & ~sclr) | srise;
      fevt_q  <= (fevt_q & ~fclr) | frise;
      if (reg_wr && reg_sel == SEL_SEN) sen_q <= reg_wdata;
      if (reg_wr && reg_sel == SEL_FEN) fen_q <= reg_wdata;
      any_q   <= any_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_sel)
        SEL_SCOND: reg_rdata <= scond;
        SEL_SEVT:  reg_rdata <= sevt_q;
        SEL_SEN:   reg_rdata <= sen_q;
        SEL_FCOND: reg_rdata <= flt_cond;
        SEL_FEVT:  reg_rdata <= fevt_q;
        SEL_FEN:   reg_rdata <= fen_q;
        default:   reg_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pend   <= 1'b0;
      idx    <= 2'd0;
      addr_q <= '0;
    end else if (!busy) begin
      if (req || pend) begin
        busy   <= 1'b1;
        pend   <= 1'b0;
        idx    <= 2'd0;
        addr_q <= unit_addr;
      end
    end else begin
      if (req) pend <= 1'b1;
      if (msg_ready) begin
        idx <= idx + 2'd1;
        if (idx == 2'd2) busy <= 1'b0;
      end
    end
  end

  wire [ADDR_W-1:0] tens = addr_q / TEN;
  wire [ADDR_W-1:0] ones = addr_q % TEN;

  assign msg_valid = busy;
  always_comb begin
    case (idx)
      2'd0:    msg_data = BANG;
      2'd1:    msg_data = ZERO_CH + 8'(tens);
      default: msg_data = ZERO_CH + 8'(ones);
    endcase
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sevt_q & ~STAT_MASK) == '0);                                        // R2
  AST_RISE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (srise != '0) |=> ((sevt_q & $past(srise)) == $past(srise)));        // R3
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_sevt || wr_sevt) |=> ((sevt_q & $past(sevt_q)) == $past(sevt_q))); // R4
  AST_FIRST_BANG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> msg_data == BANG);                              // R8
  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data)));     // R9
  AST_PEND_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pend) |=> busy);                                           // R10
endmodule

// File: tb/srq_status_events_tb.sv
module srq_status_events_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] stat_cond = '0, flt_cond = '0, reg_wdata = '0, reg_rdata;
  logic [6:0]  unit_addr = 7'd6;
  logic [2:0]  reg_sel = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0, msg_ready = 1'b0, msg_valid;
  logic [7:0]  msg_data;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  srq_status_events dut_i (
    .clk(clk), .rst_n(rst_n), .stat_cond(stat_cond), .flt_cond(flt_cond),
    .unit_addr(unit_addr), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_data(msg_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready));

  localparam logic [22:0] ADDR_TBL [6] = '{
    {7'd0, 8'h30, 8'h30}, {7'd9, 8'h30, 8'h39}, {7'd10, 8'h31, 8'h30},
    {7'd31, 8'h33, 8'h31}, {7'd47, 8'h34, 8'h37}, {7'd99, 8'h39, 8'h39}};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [15:0] d);
    reg_sel = sel; reg_rd = 1'b1;
    tick();
    reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic collect(output logic [23:0] m);
    int n = 0;
    m = '0;
    msg_ready = 1'b1;
    for (int c = 0; c < 40 && n < 3; c++) begin
      if (msg_valid) begin m = {m[15:0], msg_data}; n++; end
      tick();
    end
    msg_ready = 1'b0;
  endtask

  task automatic quiet(input int cyc, input string req);
    bit seen = 1'b0;
    for (int c = 0; c < cyc; c++) begin tick(); if (msg_valid) seen = 1'b1; end
    check(!seen, req, 32'(seen), 0);
  endtask

  initial begin
    logic [15:0] d;
    logic [23:0] m;
    tick(); tick();
    check(msg_valid == 1'b0, "R1 idle after reset", 32'(msg_valid), 0);
    rst_n = 1'b1;
    tick();
    rd(3'd1, d); check(d == 16'h0, "R1 status event reset", d, 0);
    rd(3'd2, d); check(d == 16'h0, "R1 status enable reset", d, 0);

    stat_cond = 16'hFFFF; flt_cond = 16'hA5A5;
    rd(3'd0, d); check(d == 16'h7FFF, "R2 status condition reserved bit", d, 16'h7FFF);
    rd(3'd3, d); check(d == 16'hA5A5, "R1 fault condition", d, 16'hA5A5);
    rd(3'd1, d); check(d == 16'h7FFF, "R3 status events latched", d, 16'h7FFF);
    rd(3'd1, d); check(d == 16'h0, "R4 read clears", d, 0);
    rd(3'd4, d); check(d == 16'hA5A5, "R3 fault events latched", d, 16'hA5A5);
    stat_cond = '0; flt_cond = '0;
    tick();
    rd(3'd1, d); check(d == 16'h0, "R3 falling edge sets nothing", d, 0);

    stat_cond = 16'h0008; tick(); stat_cond = '0; tick();
    stat_cond = 16'h0008; tick(); stat_cond = '0; tick();
    rd(3'd0, d); check(d == 16'h0, "R1 condition gone", d, 0);
    rd(3'd1, d); check(d == 16'h0008, "R4 short repeated pulse kept once", d, 16'h0008);

    stat_cond = 16'h0006; tick(); stat_cond = '0;
    wr(3'd1, 16'h0002);
    rd(3'd1, d); check(d == 16'h0004, "R5 write one to clear", d, 16'h0004);

    stat_cond = 16'h0010;
    rd(3'd1, d); check(d == 16'h0, "R4 read returns old content", d, 0);
    rd(3'd1, d); check(d == 16'h0010, "R4 rise during clearing read kept", d, 16'h0010);
    stat_cond = '0;

    wr(3'd2, 16'h0001);
    rd(3'd2, d); check(d == 16'h0001, "R6 status enable readback", d, 1);
    wr(3'd5, 16'h0001);
    rd(3'd5, d); check(d == 16'h0001, "R6 fault enable readback", d, 1);
    stat_cond = 16'h0004;
    quiet(6, "R6 masked event no message");
    stat_cond = '0; rd(3'd1, d);

    unit_addr = 7'd6;
    stat_cond = 16'h0001;
    tick();
    check(msg_valid == 1'b0, "R8 valid not yet", 32'(msg_valid), 0);
    tick();
    check(msg_valid && msg_data == 8'h21, "R8 valid on second edge with bang", {23'd0, msg_valid, msg_data}, 32'h121);
    unit_addr = 7'd55;
    tick(); tick(); tick();
    check(msg_valid && msg_data == 8'h21, "R9 byte held without ready", {23'd0, msg_valid, msg_data}, 32'h121);
    collect(m);
    check(m == 24'h213036, "R8 message for address 6", m, 24'h213036);
    flt_cond = 16'h0001;
    quiet(6, "R7 no request while already non-zero");
    stat_cond = '0; flt_cond = '0; tick();
    rd(3'd1, d); rd(3'd4, d); tick();

    for (int i = 0; i < 6; i++) begin
      unit_addr = ADDR_TBL[i][22:16];
      stat_cond = 16'h0001;
      collect(m);
      check(m == {8'h21, ADDR_TBL[i][15:0]}, "R8 address digits", m, {8'h21, ADDR_TBL[i][15:0]});
      stat_cond = '0; tick();
      rd(3'd1, d); tick();
    end

    unit_addr = 7'd6;
    stat_cond = 16'h0001; tick(); tick();
    check(msg_valid == 1'b1, "R10 first message started", 32'(msg_valid), 1);
    rd(3'd1, d);
    flt_cond = 16'h0001; tick(); tick();
    rd(3'd4, d); flt_cond = '0; tick();
    flt_cond = 16'h0001; tick(); tick();
    collect(m);
    check(m == 24'h213036, "R10 first message", m, 24'h213036);
    collect(m);
    check(m == 24'h213036, "R10 pending message sent", m, 24'h213036);
    msg_ready = 1'b1;
    quiet(10, "R10 only one pending");
    msg_ready = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule